// File: doc/BRIEF.md
# Eight-Point Forward DCT Pipeline

This block turns a row of eight signed samples into eight cosine-transform coefficients every clock cycle. It is the one-dimensional engine that a row/column image transform calls twice per block. The arithmetic is factored rather than a full matrix product. One level of sum/difference pairs splits the row into an even half and an odd half. The even half takes a second sum/difference level and one plane rotation. The odd half takes two plane rotations, a sum/difference level, and a final scaling by the square root of one half.

All eight samples arrive in parallel together with a valid strobe. All eight coefficients leave in parallel four cycles later with their own valid strobe, and a new row can enter on every cycle. Constants are signed fixed-point values with 12 fractional bits. Each rotation output is rounded once, after its two products are summed. The final halving rounds up at the half. Results are clamped to the 10-bit signed range.

The coefficients equal the orthonormal transform scaled by √2: coefficient 0 is half the sample sum, and coefficient k (k ≥ 1) is Σ x[n]·cos((2n+1)kπ/16)/√2.

Top module: `dctFwd8`

## Requirements
- R1: `outValid` is high in exactly the cycles that follow by four clock edges a cycle in which `inValid` was sampled high. One row is accepted per cycle, rows leave in arrival order, and no row is lost or duplicated.
- R2: When `inValid` is low, `inSamples` has no effect. While `outValid` is low, `outCoefs` keeps its previous value.
- R3: While `rstN` is low and after its release, before any row has been accepted, `outValid` is 0 and `outCoefs` is all zeros.
- R4: Sample n occupies `inSamples[8n+7:8n]` and coefficient k occupies `outCoefs[10k+9:10k]`, both two's complement. Coefficient 0 equals floor((Σx + 1)/2).
- R5: A row whose eight samples are all equal gives zero in coefficients 1 to 7.
- R6: Even half. Let a_i = x_i + x_(7−i) for i < 4. Let b0 = a0+a3, b1 = a1+a2, b2 = a1−a2, b3 = a0−a3. Define rf(v) = floor((v + 2048)/4096) and h(v) = floor((v+1)/2). Then coefficient 0 = h(b0+b1), coefficient 4 = h(b0−b1), coefficient 2 = h(rf(2217·b2 + 5352·b3)), and coefficient 6 = h(rf(2217·b3 − 5352·b2)).
- R7: Odd half. Let a_(7−i) = x_i − x_(7−i). Let o4 = rf(3406·a4 + 2276·a7), o7 = rf(3406·a7 − 2276·a4), o5 = rf(4017·a5 + 799·a6), o6 = rf(4017·a6 − 799·a5). Let p4 = o4+o6, p6 = o4−o6, p7 = o7+o5, p5 = o7−o5. Then coefficient 1 = h(p7+p4), coefficient 7 = h(p7−p4), coefficient 3 = rf(2896·p5), and coefficient 5 = rf(2896·p6).
- R8: Every result from R6 and R7 is clamped to [−512, 511] before it is output, including rows of full-scale samples.
- R9: Each coefficient lies within 2 of the real-valued scaled transform given in the description.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Row on `inSamples` is valid this cycle |
| inSamples | input | 64 | Eight signed 8-bit samples, sample n at bits 8n+7:8n |
| outValid | output | 1 | `outCoefs` carries a new row this cycle |
| outCoefs | output | 80 | Eight signed 10-bit coefficients, coefficient k at bits 10k+9:10k |

## Verification
A dropped or stuck bit in the valid pipeline shows at the ports exactly four cycles after the row that carried it, as a missing, extra or misplaced `outValid` pulse. The bench pairs every output with the cycle of its input to catch this. A wrong value held in any level register, or a wrong rotation constant, shows within four cycles as a mismatch in a single coefficient group. An odd-half fault disturbs only coefficients 1, 3, 5 and 7, while an even-half fault disturbs coefficients 0, 2, 4 and 6. The bench therefore reports each coefficient against its own requirement. A level that loads when it should not shows as `outCoefs` moving while `outValid` is low.

// File: rtl/dctPkg.sv
package dctPkg;
  localparam int NPT    = 8;   // points per transform
  localparam int LEVELS = 4;   // register levels in the flow graph
  localparam int FRAC   = 12;  // fractional bits of the constants
  localparam int CW     = 14;  // constant width, signed

  // rotation constants, value * 2^FRAC rounded
  localparam logic signed [CW-1:0] K_COS3   = 14'sd3406;  // cos(3pi/16)
  localparam logic signed [CW-1:0] K_SIN3   = 14'sd2276;  // sin(3pi/16)
  localparam logic signed [CW-1:0] K_COS1   = 14'sd4017;  // cos(pi/16)
  localparam logic signed [CW-1:0] K_SIN1   = 14'sd799;   // sin(pi/16)
  localparam logic signed [CW-1:0] K_R2COS6 = 14'sd2217;  // sqrt2*cos(6pi/16)
  localparam logic signed [CW-1:0] K_R2SIN6 = 14'sd5352;  // sqrt2*sin(6pi/16)
  localparam logic signed [CW-1:0] K_RHALF  = 14'sd2896;  // sqrt(1/2)
  localparam logic signed [CW-1:0] K_ZERO   = 14'sd0;

  typedef struct packed {
    logic [LEVELS-1:0] load;  // load enable per level, level 0 first
  } dctStrobes_t;
endpackage

// File: rtl/dctRotator.sv
// Plane rotation: four products, two sums, one rounding per output.
module dctRotator #(
  parameter int IW   = 13,
  parameter int CW   = 14,
  parameter int FRAC = 12,
  parameter logic signed [CW-1:0] COS_K = '0,
  parameter logic signed [CW-1:0] SIN_K = '0
) (
  input  logic signed [IW-1:0] i0,
  input  logic signed [IW-1:0] i1,
  output logic signed [IW-1:0] o0,
  output logic signed [IW-1:0] o1
);
  localparam int PW = IW + CW + 1;
  localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [PW-1:0] acc0, acc1;

  always_comb begin
    acc0 = PW'(COS_K) * PW'(i0) + PW'(SIN_K) * PW'(i1) + HALF;
    acc1 = PW'(COS_K) * PW'(i1) - PW'(SIN_K) * PW'(i0) + HALF;
    o0   = acc0[FRAC +: IW];
    o1   = acc1[FRAC +: IW];
  end
endmodule

// File: rtl/dctCtrl.sv
module dctCtrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output dctPkg::dctStrobes_t stb,
  output logic                outValid
);
  import dctPkg::*;

  logic [LEVELS-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LEVELS-2:0], inValid};
  end

  assign stb.load = {validPipe[LEVELS-2:0], inValid};
  assign outValid = validPipe[LEVELS-1];
endmodule

// File: rtl/dctDatapath.sv
module dctDatapath #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dctPkg::dctStrobes_t       stb,
  input  logic [dctPkg::NPT*IN_W-1:0]  samples,
  output logic [dctPkg::NPT*OUT_W-1:0] coefs
);
  import dctPkg::*;

  localparam int IW = IN_W + 5;
  localparam logic signed [IW-1:0] MAXV = IW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [IW-1:0] MINV = IW'(-(1 << (OUT_W-1)));
  localparam logic signed [IW-1:0] ONE  = signed'(IW'(1));

  logic signed [IN_W-1:0]  x  [NPT];
  logic signed [IW-1:0]    s1 [NPT];
  logic signed [IW-1:0]    s2 [NPT];
  logic signed [IW-1:0]    s3 [NPT];
  logic signed [OUT_W-1:0] q  [NPT];
  logic signed [IW-1:0]    n1 [NPT];
  logic signed [IW-1:0]    n2 [NPT];
  logic signed [IW-1:0]    n3 [NPT];
  logic signed [IW-1:0]    pre[NPT];
  logic signed [OUT_W-1:0] nq [NPT];

  logic signed [IW-1:0] rot3a, rot3b, rot1a, rot1b, rot6a, rot6b, sclA, sclB;

  function automatic logic signed [IW-1:0] halve(input logic signed [IW-1:0] v);
    return (v + ONE) >>> 1;
  endfunction

  for (genvar n = 0; n < NPT; n++) begin : g_io
    assign x[n] = samples[n*IN_W +: IN_W];
    assign coefs[n*OUT_W +: OUT_W] = q[n];
    assign nq[n] = (pre[n] > MAXV) ? MAXV[OUT_W-1:0] :
                   (pre[n] < MINV) ? MINV[OUT_W-1:0] : pre[n][OUT_W-1:0];
  end

  // level 1: outer butterflies
  always_comb begin
    for (int i = 0; i < NPT/2; i++) begin
      n1[i]         = IW'(x[i]) + IW'(x[NPT-1-i]);
      n1[NPT-1-i]   = IW'(x[i]) - IW'(x[NPT-1-i]);
    end
  end

  dctRotator #(.IW(IW), .CW(CW), .FRAC(FRAC), .COS_K(K_COS3), .SIN_K(K_SIN3))
    u_rot3 (.i0(s1[4]), .i1(s1[7]), .o0(rot3a), .o1(rot3b));
  dctRotator #(.IW(IW), .CW(CW), .FRAC(FRAC), .COS_K(K_COS1), .SIN_K(K_SIN1))
    u_rot1 (.i0(s1[5]), .i1(s1[6]), .o0(rot1a), .o1(rot1b));

  // level 2: even butterflies, odd rotations
  always_comb begin
    n2[0] = s1[0] + s1[3];
    n2[1] = s1[1] + s1[2];
    n2[2] = s1[1] - s1[2];
    n2[3] = s1[0] - s1[3];
    n2[4] = rot3a;
    n2[7] = rot3b;
    n2[5] = rot1a;
    n2[6] = rot1b;
  end

  dctRotator #(.IW(IW), .CW(CW), .FRAC(FRAC), .COS_K(K_R2COS6), .SIN_K(K_R2SIN6))
    u_rot6 (.i0(s2[2]), .i1(s2[3]), .o0(rot6a), .o1(rot6b));

  // level 3: even outputs, odd butterflies
  always_comb begin
    n3[0] = s2[0] + s2[1];
    n3[4] = s2[0] - s2[1];
    n3[2] = rot6a;
    n3[6] = rot6b;
    n3[1] = s2[4] + s2[6];
    n3[3] = s2[4] - s2[6];
    n3[7] = s2[7] + s2[5];
    n3[5] = s2[7] - s2[5];
  end

  // sqrt(1/2) scaling on the two middle odd terms
  dctRotator #(.IW(IW), .CW(CW), .FRAC(FRAC), .COS_K(K_RHALF), .SIN_K(K_ZERO))
    u_scale (.i0(s3[5]), .i1(s3[3]), .o0(sclA), .o1(sclB));

  // level 4: halving, scaling, clamp
  always_comb begin
    pre[0] = halve(s3[0]);
    pre[4] = halve(s3[4]);
    pre[2] = halve(s3[2]);
    pre[6] = halve(s3[6]);
    pre[1] = halve(s3[7] + s3[1]);
    pre[7] = halve(s3[7] - s3[1]);
    pre[3] = sclA;
    pre[5] = sclB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPT; i++) begin
        s1[i] <= '0;
        s2[i] <= '0;
        s3[i] <= '0;
        q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NPT; i++) begin
        if (stb.load[0]) s1[i] <= n1[i];
        if (stb.load[1]) s2[i] <= n2[i];
        if (stb.load[2]) s3[i] <= n3[i];
        if (stb.load[3]) q[i]  <= nq[i];
      end
    end
  end
endmodule

// File: rtl/dctFwd8.sv
module dctFwd8 #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [8*IN_W-1:0]   inSamples,
  output logic                outValid,
  output logic [8*OUT_W-1:0]  outCoefs
);
  dctPkg::dctStrobes_t stb;

  dctCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  dctDatapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .samples(inSamples), .coefs(outCoefs)
  );
endmodule

// File: rtl/dctChecker.sv
module dctChecker #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [8*IN_W-1:0]  inSamples,
  input logic               outValid,
  input logic [8*OUT_W-1:0] outCoefs
);
  localparam int SW = IN_W + 4;
  localparam int LV = dctPkg::LEVELS;

  logic [2:0]           sinceRst;
  logic signed [SW-1:0] sumNow, dcNow, dcGot;
  logic                 flatNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  always_comb begin
    sumNow  = '0;
    flatNow = inValid;
    for (int n = 0; n < 8; n++) begin
      sumNow = sumNow + SW'($signed(inSamples[n*IN_W +: IN_W]));
      if (inSamples[n*IN_W +: IN_W] != inSamples[IN_W-1:0]) flatNow = 1'b0;
    end
    dcNow = (sumNow + signed'(SW'(1))) >>> 1;
    dcGot = SW'($signed(outCoefs[OUT_W-1:0]));
  end

  // R1: valid leaves exactly four edges after it entered
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(LV)) |-> (outValid == $past(inValid, LV)));

  // R2: coefficients only move together with a valid output
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && !outValid) |-> $stable(outCoefs));

  // R4: coefficient 0 is the rounded half sum of the row
  a_r4_dc_value: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(LV) && outValid) |-> (dcGot == $past(dcNow, LV)));

  // R5: a flat row has no AC energy
  a_r5_flat_ac_zero: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'(LV) && outValid && $past(flatNow, LV))
      |-> (outCoefs[8*OUT_W-1:OUT_W] == '0));
endmodule

bind dctFwd8 dctChecker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSamples(inSamples),
  .outValid(outValid), .outCoefs(outCoefs)
);

// File: tb/dctFwd8_tb.sv
module dctFwd8_tb;
  localparam int CLK_P = 10;
  localparam int QN    = 64;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inSamples = '0;
  logic        outValid;
  logic [79:0] outCoefs;

  int errs = 0, checks = 0, cyc = 0;
  int pushes = 0, pops = 0;
  logic [63:0] qv [QN];
  int          qc [QN];
  logic        qFlat [QN];
  logic        qXtr [QN];
  int          wr = 0, rd = 0;
  logic [79:0] lastOut = '0;
  bit          finished = 1'b0;

  dctFwd8 u_dut (.clk(clk), .rstN(rstN), .inValid(inValid), .inSamples(inSamples),
                 .outValid(outValid), .outCoefs(outCoefs));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rf(int v); return (v + 2048) >>> 12; endfunction
  function automatic int hv(int v); return (v + 1) >>> 1; endfunction
  function automatic int sat(int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  // expected coefficients from the R6/R7 definitions
  function automatic logic [79:0] model(logic [63:0] v);
    int x[8], a[8], y[8];
    int b0, b1, b2, b3, o4, o5, o6, o7, p4, p5, p6, p7;
    logic [79:0] r;
    for (int n = 0; n < 8; n++) x[n] = $signed(v[n*8 +: 8]);
    for (int i = 0; i < 4; i++) begin
      a[i] = x[i] + x[7-i];
      a[7-i] = x[i] - x[7-i];
    end
    b0 = a[0] + a[3]; b1 = a[1] + a[2]; b2 = a[1] - a[2]; b3 = a[0] - a[3];
    o4 = rf(3406*a[4] + 2276*a[7]); o7 = rf(3406*a[7] - 2276*a[4]);
    o5 = rf(4017*a[5] + 799*a[6]);  o6 = rf(4017*a[6] - 799*a[5]);
    p4 = o4 + o6; p6 = o4 - o6; p7 = o7 + o5; p5 = o7 - o5;
    y[0] = hv(b0 + b1); y[4] = hv(b0 - b1);
    y[2] = hv(rf(2217*b2 + 5352*b3)); y[6] = hv(rf(2217*b3 - 5352*b2));
    y[1] = hv(p7 + p4); y[7] = hv(p7 - p4);
    y[3] = rf(2896*p5); y[5] = rf(2896*p6);
    for (int k = 0; k < 8; k++) r[k*10 +: 10] = 10'(sat(y[k]));
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [63:0] v, bit xtr);
    bit flat = 1'b1;
    for (int n = 1; n < 8; n++) if (v[n*8 +: 8] != v[7:0]) flat = 1'b0;
    @(negedge clk);
    inValid = 1'b1;
    inSamples = v;
    qv[wr] = v; qc[wr] = cyc; qFlat[wr] = flat; qXtr[wr] = xtr;
    wr = (wr + 1) % QN;
    pushes++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inSamples = {$urandom, $urandom};
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rd == wr) check(1'b0, "R1", "outValid without pending row", 1, 0);
      else begin
        logic [79:0] e;
        real acc;
        int worst;
        e = model(qv[rd]);
        check(cyc - qc[rd] == 4, "R1", "latency", cyc - qc[rd], 4);
        for (int k = 0; k < 8; k++) begin
          int ya, ye;
          ya = $signed(outCoefs[k*10 +: 10]);
          ye = $signed(e[k*10 +: 10]);
          if (k == 0)           check(ya == ye, "R4", "coef0", ya, ye);
          else if (k % 2 == 0)  check(ya == ye, "R6", $sformatf("coef%0d", k), ya, ye);
          else                  check(ya == ye, "R7", $sformatf("coef%0d", k), ya, ye);
        end
        if (qFlat[rd])
          check(outCoefs[79:10] == '0, "R5", "flat row AC", outCoefs[79:10], 0);
        if (qXtr[rd])
          check(outCoefs == e, "R8", "full-scale row clamp", outCoefs, e);
        worst = 0;
        for (int k = 0; k < 8; k++) begin
          int d;
          acc = 0.0;
          for (int n = 0; n < 8; n++)
            acc += real'($signed(qv[rd][n*8 +: 8])) *
                   $cos((2*n + 1) * k * 3.141592653589793 / 16.0);
          acc = (k == 0) ? acc / 2.0 : acc / $sqrt(2.0);
          d = $rtoi(($signed(outCoefs[k*10 +: 10]) - acc) * 100.0);
          if (d < 0) d = -d;
          if (d > worst) worst = d;
        end
        check(worst <= 200, "R9", "distance to real transform x100", worst, 200);
        lastOut = outCoefs;
        rd = (rd + 1) % QN;
        pops++;
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", WDOG, WDOG);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R3", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R3", "outValid after reset", outValid, 0);
    check(outCoefs == '0, "R3", "outCoefs after reset", outCoefs, 0);

    // directed rows
    push(64'h0, 1'b0);
    push({8{8'h7F}}, 1'b1);
    push({8{8'h80}}, 1'b1);
    push({8{8'h25}}, 1'b0);
    push(64'h0000_0000_0000_0064, 1'b0);
    push(64'h6400_0000_0000_0000, 1'b0);
    push(64'h7F80_807F_7F80_807F, 1'b1);
    push(64'h807F_7F80_807F_7F80, 1'b1);
    push(64'h7F80_7F80_7F80_7F80, 1'b1);
    push(64'h8080_8080_7F7F_7F7F, 1'b1);
    push(64'h7F7F_7F7F_8080_8080, 1'b1);
    idle(6);

    // random rows, bursts with gaps
    for (int i = 0; i < 400; i++) begin
      push({$urandom, $urandom}, 1'b0);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(8);

    // R2: changing samples with inValid low leaves the outputs alone
    for (int i = 0; i < 6; i++) begin
      idle(1);
      #1;
      check(outValid == 1'b0, "R2", "outValid idle", outValid, 0);
      check(outCoefs == lastOut, "R2", "outCoefs held", outCoefs, lastOut);
    end

    check(pushes == pops, "R1", "rows out vs rows in", pops, pushes);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule